// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small first-in, first-out store of instruction bytes topped up from a 16-bit code memory. Its fetch controller holds a 20-bit prefetch pointer. Whenever enough room is free, it issues a word read at that pointer, pushes the returned bytes in address order and advances the pointer. It does this whether or not the consumer is currently taking bytes, so a stalled execution stage finds its next bytes already waiting.

The consumer reads one byte at a time through a valid/ready handshake. When control flow changes, a redirect pulse with a target address empties the store and points the controller at the target. Any word read already in flight at that moment is thrown away when it returns. The fetch address is a full 20-bit physical byte address supplied from outside, and the memory port has a hold-until-ready request phase followed by a single-cycle response.

Top module: `prefetch_queue`

## Requirements
- R1: While `rst` is high at a clock edge, the queue becomes empty (`out_valid` low on the next cycle) and the prefetch pointer is loaded from `reset_vector`. The first request after reset carries that address.
- R2: Bytes reach `out_byte` in the order of their addresses, starting at the reset vector or the last redirect target. A byte is removed only at a clock edge where `out_valid` and `out_ready` are both high.
- R3: The queue never holds more than 6 bytes. A new request is raised only when at least 2 slots are free, so a full queue, or one with a single free slot, produces no `mem_req`.
- R4: With `out_ready` held low, the controller keeps fetching until the queue cannot take another word. From an even address it stops after 3 requests and 6 bytes.
- R5: Returned words are little-endian: `mem_rdata[7:0]` is the byte at the even address and `mem_rdata[15:8]` the byte at the odd address. A request to an even address enqueues the low byte then the high byte. A request to an odd address enqueues only the high byte.
- R6: The prefetch pointer advances by the number of bytes enqueued (1 or 2), so each request address equals the previous one plus 1 (odd) or 2 (even).
- R7: A cycle with `redirect_valid` high empties the queue: `out_valid` is low on the next cycle, and the next request uses `redirect_addr`.
- R8: If a redirect occurs while a request is accepted but its response has not yet arrived, or in the cycle the request is accepted, the response to that request is discarded.
- R9: A push from a returning response and a pop by the consumer may happen at the same clock edge without losing or reordering any byte.
- R10: Once raised, `mem_req` and `mem_addr` stay unchanged until a cycle with `mem_ready` high, unless a redirect withdraws the request. At most one request is outstanding, and a response (`mem_rvalid`) arrives no earlier than the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vector | input | 20 | Fetch address loaded at reset |
| redirect_valid | input | 1 | Control-transfer pulse: flush and refetch |
| redirect_addr | input | 20 | Target byte address of the redirect |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 20 | Byte address of the requested code |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read word, low byte at the even address |
| out_valid | output | 1 | Head byte is available |
| out_byte | output | 8 | Head byte |
| out_ready | input | 1 | Consumer takes the head byte |

## Verification
The bench stalls the consumer from both an even and an odd start address. A controller that ignores the two-slot rule would overrun the store or issue a fourth request, and one that mishandles odd addresses would enqueue a wrong low byte or skip an address. Redirects are placed while a word read is in flight and in the exact cycle a request is accepted. A design that lets that stale response through would show a byte from the old stream ahead of the target's bytes. A scoreboard compares every consumed byte against the address sequence and the expected request addresses, including edges where a response push and a consumer pop coincide. A lost or reordered byte there would show up as a mismatch.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } pfq_fstate_e;
endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [1:0]        push_cnt,
  input  logic [BYTE_W-1:0] push_b0,
  input  logic [BYTE_W-1:0] push_b1,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic              head_valid,
  output logic [CW-1:0]     count
);
  logic [BYTE_W-1:0] slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic pop_ok;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign pop_ok     = pop && (count != '0);
  assign head       = slots[rd_ptr];
  assign head_valid = (count != '0);

  // storage without reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_cnt != 2'd0) slots[wr_ptr] <= push_b0;
    if (push_cnt == 2'd2) slots[wrap_inc(wr_ptr)] <= push_b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop_ok) rd_ptr <= wrap_inc(rd_ptr);
      if (push_cnt == 2'd2)      wr_ptr <= wrap_inc(wrap_inc(wr_ptr));
      else if (push_cnt == 2'd1) wr_ptr <= wrap_inc(wr_ptr);
      count <= CW'(count + CW'(push_cnt) - CW'(pop_ok));
    end
  end

  // R3: a push never takes occupancy beyond DEPTH
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push_cnt != 2'd0 && !flush) |-> (int'(count) - int'(pop_ok) + int'(push_cnt) <= DEPTH));

  // R3: occupancy register stays in range
  a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     reset_vector,
  input  logic              redirect,
  input  logic [AW-1:0]     target,
  input  logic [CW-1:0]     count,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [1:0]        push_cnt,
  output logic [BYTE_W-1:0] push_b0,
  output logic [BYTE_W-1:0] push_b1
);
  pfq_fstate_e   state;
  logic [AW-1:0] pf_ptr;
  logic          discard;
  logic          room;

  assign room = (count <= CW'(DEPTH - 2));

  always_comb begin
    push_cnt = 2'd0;
    if (state == FS_WAIT && mem_rvalid && !discard && !redirect)
      push_cnt = mem_addr[0] ? 2'd1 : 2'd2;
    push_b0 = mem_addr[0] ? mem_rdata[WORD_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];
    push_b1 = mem_rdata[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FS_IDLE;
      pf_ptr   <= reset_vector;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      discard  <= 1'b0;
    end else begin
      if (push_cnt != 2'd0) pf_ptr <= pf_ptr + AW'(push_cnt);
      if (redirect) pf_ptr <= target;
      case (state)
        FS_IDLE: begin
          if (!redirect && room) begin
            state    <= FS_REQ;
            mem_req  <= 1'b1;
            mem_addr <= pf_ptr;
          end
        end
        FS_REQ: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            state   <= FS_WAIT;
            if (redirect) discard <= 1'b1;
          end else if (redirect) begin
            mem_req <= 1'b0;
            state   <= FS_IDLE;
          end
        end
        FS_WAIT: begin
          if (mem_rvalid) begin
            state   <= FS_IDLE;
            discard <= 1'b0;
          end else if (redirect) begin
            discard <= 1'b1;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  // R1: reset loads the pointer from the vector input
  a_r1_vector_load: assert property (@(posedge clk)
    rst |=> (pf_ptr == $past(reset_vector)));

  // R10: a pending request holds until accepted
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready && !redirect) |=> (mem_req && $stable(mem_addr)));

  // R3: a request only starts when two slots are free
  a_r3_room_on_issue: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (count <= CW'(DEPTH - 2)));

  // R6: pointer moves past exactly the bytes enqueued
  a_r6_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    (push_cnt != 2'd0 && !redirect) |=> (pf_ptr == $past(mem_addr) + AW'($past(push_cnt))));

  // R5: after any push the pointer is word aligned
  a_r5_aligned_after: assert property (@(posedge clk) disable iff (rst)
    (push_cnt != 2'd0 && !redirect) |=> !pf_ptr[0]);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int AW     = 20,
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     reset_vector,
  input  logic              redirect_valid,
  input  logic [AW-1:0]     redirect_addr,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  input  logic              out_ready
);
  logic [1:0]        push_cnt;
  logic [BYTE_W-1:0] push_b0, push_b1;
  logic [CW-1:0]     count;

  pfq_fetch #(.AW(AW), .DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_fetch (
    .clk(clk), .rst(rst), .reset_vector(reset_vector),
    .redirect(redirect_valid), .target(redirect_addr), .count(count),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .push_cnt(push_cnt), .push_b0(push_b0), .push_b1(push_b1)
  );

  pfq_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst(rst), .flush(redirect_valid),
    .push_cnt(push_cnt), .push_b0(push_b0), .push_b1(push_b1),
    .pop(out_valid && out_ready),
    .head(out_byte), .head_valid(out_valid), .count(count)
  );

  // R1: reset leaves the consumer side empty
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R7: a redirect empties the queue by the next cycle
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !out_valid);
endmodule

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] reset_vector = '0;
  logic          redirect_valid = 1'b0;
  logic [AW-1:0] redirect_addr = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ready = 1'b0;
  logic          mem_rvalid = 1'b0;
  logic [15:0]   mem_rdata = '0;
  logic          out_valid;
  logic [7:0]    out_byte;
  logic          out_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]    exp_q[$];
  logic [AW-1:0] exp_fetch;
  bit            first_req;
  int            acc_cnt;
  int            pop_cnt;
  int            ready_mode = 0;
  int            lat = 2;
  int            resp_cnt = 0;
  logic [AW-1:0] resp_addr;
  int            cyc = 0;

  always #5 clk = ~clk;

  prefetch_queue u_dut (
    .clk(clk), .rst(rst), .reset_vector(reset_vector),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_byte(out_byte), .out_ready(out_ready)
  );

  function automatic logic [7:0] code_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_expect(input logic [AW-1:0] t);
    exp_q.delete();
    for (int i = 0; i < 64; i++) exp_q.push_back(code_byte(t + AW'(i)));
    exp_fetch = t;
    first_req = 1'b1;
    acc_cnt   = 0;
  endtask

  // memory model: one-cycle response lat cycles after acceptance, checks request order
  always begin
    @(negedge clk);
    cyc++;
    mem_ready  = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
    mem_rvalid = 1'b0;
    if (resp_cnt > 0) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = {code_byte({resp_addr[AW-1:1], 1'b1}), code_byte({resp_addr[AW-1:1], 1'b0})};
      end
    end
    #3;
    if (!rst && mem_req && mem_ready && !redirect_valid) begin
      // R6 / R1: request address follows the byte sequence
      check(mem_addr == exp_fetch, first_req ? "R1" : "R6", int'(mem_addr), int'(exp_fetch));
      first_req = 1'b0;
      exp_fetch = exp_fetch + (exp_fetch[0] ? AW'(1) : AW'(2));
      acc_cnt++;
    end
    if (!rst && mem_req && mem_ready) begin
      resp_addr = mem_addr;
      resp_cnt  = lat;
    end
  end

  // scoreboard monitor: every consumed byte compared with the expected stream
  always begin
    @(negedge clk);
    #3;
    if (!rst && out_valid && out_ready && !redirect_valid) begin
      pop_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", int'(out_byte), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        // R9 when a response push coincides with this pop; R2/R5 otherwise
        check(out_byte == e, mem_rvalid ? "R9" : "R2_R5", int'(out_byte), int'(e));
      end
    end
  end

  task automatic do_reset(input logic [AW-1:0] v);
    @(negedge clk);
    rst = 1'b1;
    reset_vector = v;
    load_expect(v);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #3;
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
  endtask

  task automatic redirect_to(input logic [AW-1:0] t);
    @(negedge clk);
    redirect_valid = 1'b1;
    redirect_addr  = t;
    load_expect(t);
    @(negedge clk);
    redirect_valid = 1'b0;
    #3;
    check(out_valid == 1'b0, "R7", int'(out_valid), 0);
  endtask

  // redirect raised in the very cycle a request is being accepted
  task automatic redirect_on_accept(input logic [AW-1:0] t);
    bit hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      #1;
      if (mem_req && mem_ready) begin
        hit = 1'b1;
        redirect_valid = 1'b1;
        redirect_addr  = t;
        load_expect(t);
      end
    end
    @(negedge clk);
    redirect_valid = 1'b0;
    #3;
    check(out_valid == 1'b0, "R7", int'(out_valid), 0);
  endtask

  task automatic wait_accepted();
    bit hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      #3;
      if (mem_req && mem_ready) hit = 1'b1;
    end
  endtask

  initial begin
    // phase 1: reset from even vector, consumer stalled
    out_ready = 1'b0;
    ready_mode = 0;
    lat = 2;
    do_reset(20'h12340);
    repeat (40) @(negedge clk);
    #3;
    check(acc_cnt == 3, "R4", acc_cnt, 3);
    check(mem_req == 1'b0, "R3", int'(mem_req), 0);
    check(out_valid == 1'b1, "R4", int'(out_valid), 1);
    pop_cnt = 0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (40) @(negedge clk);
    check(pop_cnt >= 10, "R2", pop_cnt, 10);

    // phase 2: redirect to odd target while streaming
    redirect_to(20'h4A5B1);
    pop_cnt = 0;
    repeat (40) @(negedge clk);
    check(pop_cnt >= 10, "R5", pop_cnt, 10);

    // phase 3: odd target, consumer stalled: 1+2+2 bytes then stop
    @(negedge clk);
    out_ready = 1'b0;
    redirect_to(20'h07773);
    repeat (40) @(negedge clk);
    #3;
    check(acc_cnt == 3, "R3", acc_cnt, 3);
    check(mem_req == 1'b0, "R3", int'(mem_req), 0);
    pop_cnt = 0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (30) @(negedge clk);
    check(pop_cnt >= 5, "R2", pop_cnt, 5);

    // phase 4: redirect while a response is in flight, slow memory
    ready_mode = 1;
    lat = 5;
    wait_accepted();
    redirect_to(20'hABCD0);
    pop_cnt = 0;
    repeat (60) @(negedge clk);
    check(pop_cnt >= 6, "R8", pop_cnt, 6);

    // phase 5: redirect in the cycle of acceptance
    lat = 3;
    redirect_on_accept(20'h3C0F5);
    pop_cnt = 0;
    repeat (60) @(negedge clk);
    check(pop_cnt >= 6, "R8", pop_cnt, 6);

    // phase 6: fast memory with a stuttering consumer
    ready_mode = 0;
    lat = 1;
    redirect_to(20'h5555E);
    pop_cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      out_ready = (i % 4) != 3;
    end
    check(pop_cnt >= 20, "R9", pop_cnt, 20);
    @(negedge clk);
    out_ready = 1'b1;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule